// File: doc/BRIEF.md
# Predicated element-loop add sequencer

This block runs one element-wise add across a vector of length VL. Each source and destination register can override its element width, and each register carries a vector flag. A start pulse captures the operand register numbers, VL, a predicate mask, the per-register flags and width codes, and two sign-extension controls. From the next cycle on, the block steps through one element per cycle.

In each step it presents two element reads to an external width-aware register port, and the port answers in the same cycle. The block adds the two elements. When the predicate bit for that step is set, it issues one element write in the same cycle. The register storage lives outside the block. The port takes a register number, an element index and a width code, and returns or accepts an element aligned to bit 0.

The block signals completion with a one-cycle done pulse. Indices of scalar registers stay at element 0. A scalar destination stops the loop after its first write.

Top module: `elem_add_seq`

## Requirements
- R1: Width codes decode as 0 = 64 bits (full width, no override), 1 = 8, 2 = 16, 3 = 32. The source element width is the larger decoded width of the two source registers, and its code is driven on `rd_wc` for both reads.
- R2: Only the low source-width bits of each read word are used. `wr_data` carries only the low destination-width bits of the result with all upper bits zero, and `wr_wc` is the destination register's own width code.
- R3: The result is the first source plus the zero-extended second source, added at the full 64 bits. With `sx_src1` high, the first source is first sign-extended from the source width to 64 bits.
- R4: With `sx_res` high, the low source-width bits of the sum are sign-extended to 64 bits before the write truncation.
- R5: Iteration i runs from 0 up to VL-1, one per cycle starting in the cycle after start. `wr_en` is high in iteration i only when bit i of the predicate mask is 1.
- R6: A vector-flagged register's element index equals the iteration number, counting masked-off iterations. A register without the flag always uses index 0.
- R7: With the destination not vector-flagged, the loop ends after the iteration that performs the first write, and no later write follows.
- R8: `done` is a one-cycle pulse in the cycle after the last iteration, and `busy` is low from that cycle on. With VL = 0, `done` rises in the cycle after start and no write or iteration occurs.
- R9: A start pulse while `busy` is high is ignored. The running operation finishes with its captured settings, and no second operation follows.
- R10: After reset, `busy`, `done` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (used only when idle) |
| src1_reg | input | 5 | First source register number |
| src2_reg | input | 5 | Second source register number |
| dst_reg | input | 5 | Destination register number |
| vl | input | 7 | Vector length, 0 to 64 |
| pred | input | 64 | Predicate mask, bit i gates iteration i |
| vec_flags | input | 32 | Per-register vector flag |
| wcodes | input | 64 | Per-register 2-bit width code, register r at bits 2r+1:2r |
| sx_src1 | input | 1 | Sign-extend first source before the add |
| sx_res | input | 1 | Sign-extend result from source width |
| busy | output | 1 | Loop in progress |
| done | output | 1 | Completion pulse |
| rd_a_reg | output | 5 | Read port A register |
| rd_a_idx | output | 6 | Read port A element index |
| rd_b_reg | output | 5 | Read port B register |
| rd_b_idx | output | 6 | Read port B element index |
| rd_wc | output | 2 | Width code for both reads |
| rd_a_data | input | 64 | Element read through port A |
| rd_b_data | input | 64 | Element read through port B |
| wr_en | output | 1 | Element write strobe |
| wr_reg | output | 5 | Write register |
| wr_idx | output | 6 | Write element index |
| wr_wc | output | 2 | Write width code |
| wr_data | output | 64 | Write element, zero above its width |

## Verification
The assertions assume that the read port answers within the same cycle. They also assume that the operation settings only need to be valid in the cycle that carries an accepted start, because everything is captured there. The bench models the register port as a pure function of register, index and width code, so every read is answered at once. It also fills the upper bits of each answer with pseudo-random data, which exercises the masking. It changes the settings freely, including during a run, and it holds VL within 0 to 64, the only constraint the block places on its inputs.

// File: rtl/elem_add_seq.sv
module elem_add_seq #(
  parameter int XLEN  = 64,
  parameter int NREG  = 32,
  parameter int MAXVL = 64,
  localparam int RW = $clog2(NREG),
  localparam int IW = $clog2(MAXVL),
  localparam int LW = $clog2(MAXVL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [RW-1:0]   src1_reg,
  input  logic [RW-1:0]   src2_reg,
  input  logic [RW-1:0]   dst_reg,
  input  logic [LW-1:0]   vl,
  input  logic [MAXVL-1:0] pred,
  input  logic [NREG-1:0] vec_flags,
  input  logic [2*NREG-1:0] wcodes,
  input  logic            sx_src1,
  input  logic            sx_res,
  output logic            busy,
  output logic            done,
  output logic [RW-1:0]   rd_a_reg,
  output logic [IW-1:0]   rd_a_idx,
  output logic [RW-1:0]   rd_b_reg,
  output logic [IW-1:0]   rd_b_idx,
  output logic [1:0]      rd_wc,
  input  logic [XLEN-1:0] rd_a_data,
  input  logic [XLEN-1:0] rd_b_data,
  output logic            wr_en,
  output logic [RW-1:0]   wr_reg,
  output logic [IW-1:0]   wr_idx,
  output logic [1:0]      wr_wc,
  output logic [XLEN-1:0] wr_data
);

  function automatic int width_of(input logic [1:0] c);
    case (c)
      2'd1:    return 8;
      2'd2:    return 16;
      2'd3:    return 32;
      default: return XLEN;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] low_ones(input int n);
    logic [XLEN-1:0] one;
    one = 1;
    if (n >= XLEN) return '1;
    return (one << n) - one;
  endfunction

  logic            run, done_q, sx1_q, sxr_q;
  logic            avec, bvec, dvec;
  logic [1:0]      wca, wcb, wcd;
  logic [RW-1:0]   ra_q, rb_q, rd_q;
  logic [LW-1:0]   vl_q;
  logic [MAXVL-1:0] pred_q;
  logic [IW-1:0]   it, ia, ib, id;

  int sw, dw;
  logic [XLEN-1:0] m_s, a_op, b_op, sum, res;
  logic last, fin;

  assign sw = (width_of(wca) >= width_of(wcb)) ? width_of(wca) : width_of(wcb);
  assign dw = width_of(wcd);
  assign m_s = low_ones(sw);

  always_comb begin
    a_op = rd_a_data & m_s;
    if (sx1_q && a_op[sw-1]) a_op = a_op | ~m_s;
    b_op = rd_b_data & m_s;
    sum  = a_op + b_op;
    res  = sum;
    if (sxr_q) begin
      res = sum & m_s;
      if (res[sw-1]) res = res | ~m_s;
    end
  end

  assign busy     = run;
  assign done     = done_q;
  assign rd_a_reg = ra_q;
  assign rd_b_reg = rb_q;
  assign rd_a_idx = ia;
  assign rd_b_idx = ib;
  assign rd_wc    = (width_of(wca) >= width_of(wcb)) ? wca : wcb;
  assign wr_en    = run & pred_q[it];
  assign wr_reg   = rd_q;
  assign wr_idx   = id;
  assign wr_wc    = wcd;
  assign wr_data  = res & low_ones(dw);

  assign last = (LW'(it) + LW'(1)) == vl_q;
  assign fin  = run && (last || (pred_q[it] && !dvec));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; done_q <= 1'b0; sx1_q <= 1'b0; sxr_q <= 1'b0;
      avec <= 1'b0; bvec <= 1'b0; dvec <= 1'b0;
      wca <= '0; wcb <= '0; wcd <= '0;
      ra_q <= '0; rb_q <= '0; rd_q <= '0;
      vl_q <= '0; pred_q <= '0;
      it <= '0; ia <= '0; ib <= '0; id <= '0;
    end else begin
      done_q <= 1'b0;
      if (!run) begin
        if (start) begin
          ra_q <= src1_reg; rb_q <= src2_reg; rd_q <= dst_reg;
          avec <= vec_flags[src1_reg];
          bvec <= vec_flags[src2_reg];
          dvec <= vec_flags[dst_reg];
          wca  <= wcodes[2*src1_reg +: 2];
          wcb  <= wcodes[2*src2_reg +: 2];
          wcd  <= wcodes[2*dst_reg +: 2];
          vl_q <= vl; pred_q <= pred;
          sx1_q <= sx_src1; sxr_q <= sx_res;
          it <= '0; ia <= '0; ib <= '0; id <= '0;
          if (vl == '0) done_q <= 1'b1;
          else          run    <= 1'b1;
        end
      end else if (fin) begin
        run    <= 1'b0;
        done_q <= 1'b1;
      end else begin
        it <= it + 1'b1;
        ia <= avec ? ia + 1'b1 : '0;
        ib <= bvec ? ib + 1'b1 : '0;
        id <= dvec ? id + 1'b1 : '0;
      end
    end
  end

endmodule

// File: rtl/elem_add_seq_chk.sv
module elem_add_seq_chk #(
  parameter int RW = 5,
  parameter int IW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          wr_en,
  input logic [RW-1:0] wr_reg,
  input logic [IW-1:0] wr_idx,
  input logic [IW-1:0] rd_a_idx,
  input logic [IW-1:0] rd_b_idx,
  input logic [1:0]    rd_wc,
  input logic          avec,
  input logic          bvec,
  input logic          dvec
);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R5
  write_in_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  // R7
  scalar_dst_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !dvec) |=> !busy);

  // R6
  scalar_src_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !avec) |-> rd_a_idx == '0);

  // R6
  scalar_src_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bvec) |-> rd_b_idx == '0);

  // R6
  vec_dst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && dvec) |-> wr_idx == $past(wr_idx) + 1'b1);

  // R1
  src_width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rd_wc));

  // R9
  start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(wr_reg));

endmodule

bind elem_add_seq elem_add_seq_chk #(.RW(RW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .wr_en(wr_en), .wr_reg(wr_reg), .wr_idx(wr_idx),
  .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx), .rd_wc(rd_wc),
  .avec(avec), .bvec(bvec), .dvec(dvec)
);

// File: tb/sim_elem_add_seq.sv
module sim_elem_add_seq;
  logic clk = 0, rst_n = 0, start = 0;
  logic [4:0]  src1_reg = 0, src2_reg = 0, dst_reg = 0;
  logic [6:0]  vl = 0;
  logic [63:0] pred = 0;
  logic [31:0] vec_flags = 0;
  logic [63:0] wcodes = 0;
  logic sx_src1 = 0, sx_res = 0;
  logic busy, done, wr_en;
  logic [4:0] rd_a_reg, rd_b_reg, wr_reg;
  logic [5:0] rd_a_idx, rd_b_idx, wr_idx;
  logic [1:0] rd_wc, wr_wc;
  logic [63:0] rd_a_data, rd_b_data, wr_data;

  int total = 0, bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  elem_add_seq u0 (
    .clk, .rst_n, .start, .src1_reg, .src2_reg, .dst_reg, .vl, .pred,
    .vec_flags, .wcodes, .sx_src1, .sx_res, .busy, .done,
    .rd_a_reg, .rd_a_idx, .rd_b_reg, .rd_b_idx, .rd_wc,
    .rd_a_data, .rd_b_data, .wr_en, .wr_reg, .wr_idx, .wr_wc, .wr_data
  );

  function automatic int bw(input logic [1:0] c);
    return c == 2'd1 ? 8 : c == 2'd2 ? 16 : c == 2'd3 ? 32 : 64;
  endfunction

  function automatic logic [63:0] msk(input int n);
    return n >= 64 ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << n) - 64'd1);
  endfunction

  function automatic logic [63:0] sx(input logic [63:0] v, input int n);
    logic [63:0] t;
    t = v & msk(n);
    return t[n-1] ? (t | ~msk(n)) : t;
  endfunction

  function automatic logic [63:0] rdat(input logic [4:0] r, input logic [5:0] k,
                                       input logic [1:0] c);
    logic [63:0] x;
    x = {45'd0, r, k, c, 6'd0} + 64'd1;
    x = x * 64'h9E37_79B9_7F4A_7C15;
    x = x ^ (x >> 29);
    return x;
  endfunction

  assign rd_a_data = rdat(rd_a_reg, rd_a_idx, rd_wc);
  assign rd_b_data = rdat(rd_b_reg, rd_b_idx, rd_wc);

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_op(input logic [4:0] r1, input logic [4:0] r2, input logic [4:0] rd,
                        input int n, input logic [63:0] pm, input logic [31:0] vf,
                        input logic [63:0] wc, input bit s1, input bit sr, input bit inject);
    logic [1:0] c1, c2, cd, sc;
    int s_w, iters, nexp, k, got_it;
    bit got_done;
    logic [5:0]  e_idx[64];
    logic [63:0] e_dat[64];
    logic [63:0] a, b, s;
    c1 = wc[2*r1 +: 2]; c2 = wc[2*r2 +: 2]; cd = wc[2*rd +: 2];
    s_w = bw(c1) >= bw(c2) ? bw(c1) : bw(c2);
    sc  = bw(c1) >= bw(c2) ? c1 : c2;
    nexp = 0; iters = n;
    for (int i = 0; i < n; i++) begin
      if (pm[i]) begin
        a = rdat(r1, vf[r1] ? 6'(i) : 6'd0, sc) & msk(s_w);
        b = rdat(r2, vf[r2] ? 6'(i) : 6'd0, sc) & msk(s_w);
        if (s1) a = sx(a, s_w);
        s = a + b;
        if (sr) s = sx(s, s_w);
        e_idx[nexp] = vf[rd] ? 6'(i) : 6'd0;
        e_dat[nexp] = s & msk(bw(cd));
        nexp++;
        if (!vf[rd]) begin iters = i + 1; break; end
      end
    end
    @(negedge clk);
    src1_reg = r1; src2_reg = r2; dst_reg = rd; vl = 7'(n); pred = pm;
    vec_flags = vf; wcodes = wc; sx_src1 = s1; sx_res = sr; start = 1;
    @(negedge clk);
    start = 0;
    k = 0; got_it = 0; got_done = 0;
    for (int g = 0; g < 80; g++) begin
      if (done) begin got_done = 1; break; end
      if (busy) begin
        // R1: source width code on the read port
        if (got_it == 0) chk(rd_wc == sc, "R1", rd_wc, sc);
        got_it++;
        if (wr_en) begin
          if (k < nexp) begin
            // R2 R3 R4 data, R6 index, R2 code
            chk(wr_data == e_dat[k], "R3/R4 data", wr_data, e_dat[k]);
            chk(wr_idx == e_idx[k], "R6 index", wr_idx, e_idx[k]);
            chk(wr_reg == rd && wr_wc == cd, "R2 reg/code", {wr_reg, wr_wc}, {rd, cd});
          end
          k++;
        end
      end
      if (inject && got_it == 2) begin
        start = 1; dst_reg = rd ^ 5'd7; vl = 7'd64; pred = '1; vec_flags = ~vf;
      end else start = 0;
      @(negedge clk);
    end
    start = 0;
    chk(got_done, "R8 done", got_done, 1);
    chk(got_it == iters, "R5/R7 iterations", got_it, iters);
    chk(k == nexp, "R5/R7 writes", k, nexp);
    @(negedge clk);
    // R8 pulse, R9 nothing follows an ignored start
    chk(!done && !busy, "R8/R9 idle after done", {done, busy}, 0);
  endtask

  initial begin
    logic [31:0] vf;
    logic [63:0] wc;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R10
    chk(!busy && !done && !wr_en, "R10 reset", {busy, done, wr_en}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !wr_en, "R10 idle", {busy, done, wr_en}, 0);

    // R8 VL zero
    run_op(5'd1, 5'd2, 5'd3, 0, '1, '1, '0, 0, 0, 0);
    // all vector, full width, full length
    run_op(5'd4, 5'd5, 5'd6, 64, '1, '1, '0, 0, 0, 0);
    // R1 mixed widths: src1 8b, src2 16b, dst 32b, sign ext both
    wc = '0; wc[2*4 +: 2] = 2'd1; wc[2*5 +: 2] = 2'd2; wc[2*6 +: 2] = 2'd3;
    run_op(5'd4, 5'd5, 5'd6, 20, 64'hF0F0_3C3C_AAAA_5555, '1, wc, 1, 0, 0);
    run_op(5'd4, 5'd5, 5'd6, 20, 64'hFFFF_FFFF_FFFF_FFFF, '1, wc, 0, 1, 0);
    // R6 scalar sources, vector dest, masked-off steps
    vf = '1; vf[4] = 0; vf[5] = 0;
    run_op(5'd4, 5'd5, 5'd6, 12, 64'h0000_0000_0000_0A5A, vf, wc, 1, 1, 0);
    // R7 scalar dest, first bits masked off
    vf = '1; vf[9] = 0;
    run_op(5'd7, 5'd8, 5'd9, 30, 64'h0000_0000_0001_0010, vf, '0, 0, 0, 0);
    // R7 scalar dest, no bit set
    run_op(5'd7, 5'd8, 5'd9, 10, 64'h0000_0000_0000_FC00, vf, '0, 0, 0, 0);
    // R9 start while busy
    run_op(5'd10, 5'd11, 5'd12, 16, 64'h0000_0000_0000_FFFF, '1, '0, 0, 0, 1);

    for (int t = 0; t < 60; t++) begin
      int n;
      n = ($urandom % 4 == 0) ? 64 : int'($urandom % 40);
      run_op(5'($urandom), 5'($urandom), 5'($urandom), n,
             {$urandom, $urandom}, $urandom, {$urandom, $urandom},
             1'($urandom), 1'($urandom), (t % 7) == 3);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule